// File: doc/BRIEF.md
# Flag Offset Register Loader

This block keeps the two thresholds a FIFO flag generator compares its fill level against: an empty-side offset and a full-side offset. The level of the offset-access select input at master reset fixes, until the next master reset, how the offsets may be programmed: bit-serially through a one-bit input, or word-wide from the write data bus. The same level also picks the defaults both offsets take at master reset: 1,023 for the serial method and 127 for the parallel method.

After reset, holding the offset-access select low steers the enables to the offset registers instead of FIFO memory. A parallel write on the write clock fills the empty offset first, then the full offset, then alternates. A serial shift moves one bit per write-clock edge through a chain that is twice the offset width. Reads on the read clock return the offsets in parallel on the read-data bus, also alternating empty then full, whichever method is in force. Partial reset puts both select pointers back on the empty offset and keeps the method and the offset values.

Top module: `ofs_loader`

## Requirements
- R1: A master reset with `ofsAccN` high selects the serial method and sets both offsets to 1,023. It also clears `rdData` to zero.
- R2: A master reset with `ofsAccN` low selects the parallel method and sets both offsets to 127. It also clears `rdData` to zero.
- R3: In the parallel method, a write-clock edge with `ofsAccN` low and `wenN` low stores `dataIn[W-1:0]` into the empty offset on the first write after any reset, into the full offset on the next, and alternates after that. Bits of `dataIn` above bit W-1 are ignored.
- R4: In the serial method, a write-clock edge with `ofsAccN` low and `senN` low shifts `serIn` into a 2W-bit chain. After 2W shifts, the first bit shifted sits in bit 0 of `emptyOfs` and the last bit shifted sits in bit W-1 of `fullOfs`.
- R5: A read-clock edge with `ofsAccN` low and `renN` low loads `rdData` with the empty offset on the first read after any reset and with the full offset on the next, alternating after that. The value is zero-extended, and this works under either method. Between reads, `rdData` holds its value.
- R6: While `ofsAccN` is high, `wenN`, `senN` and `renN` change neither offset nor either select pointer.
- R7: A partial reset (`prstN` low) returns both select pointers to the empty offset and clears `rdData`. It leaves both offset values and the selected method unchanged.
- R8: The write strobe that does not belong to the selected method is ignored. `senN` has no effect under the parallel method, and `wenN` has no effect under the serial method, even when both are low on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock; drives the offset registers and the write select pointer |
| rdClk | input | 1 | Read-side clock; drives the read select pointer and `rdData` |
| mrstN | input | 1 | Master reset, active low, sampled on both clocks |
| prstN | input | 1 | Partial reset, active low, sampled on both clocks |
| ofsAccN | input | 1 | Low: enables address the offsets. At master reset: high selects serial, low selects parallel |
| senN | input | 1 | Serial shift enable, active low |
| wenN | input | 1 | Parallel write enable, active low |
| renN | input | 1 | Parallel read enable, active low |
| serIn | input | 1 | Serial offset data bit |
| dataIn | input | DW | Parallel offset write data |
| rdData | output | DW | Offset read-back data, zero-extended |
| emptyOfs | output | W | Current empty-side offset |
| fullOfs | output | W | Current full-side offset |

## Verification
The assertions assume the following about the inputs:
- Each reset is held across at least one rising edge of both clocks.
- The control inputs are stable around the clock edge that samples them.
- A read-back is not issued on the read clock while the write clock is changing the same offset. The two clocks are unrelated, so the read path does not synchronize.

The stimulus keeps to these rules. It changes every input on a falling edge of the clock that samples it, and it holds each reset for several edges of both clocks. Its write and read sequences never overlap: each read starts only after the write that precedes it has completed.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;

  typedef enum logic {
    METHOD_PAR = 1'b0,
    METHOD_SER = 1'b1
  } method_e;

  // write-clock strobes from control to datapath
  typedef struct packed {
    logic setDefault;
    logic defSerial;
    logic wrEmpty;
    logic wrFull;
    logic shift;
  } wrStb_t;

  // read-clock strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic rdEmpty;
    logic rdFull;
  } rdStb_t;

endpackage

// File: rtl/ofs_loader_ctrl.sv
module ofs_loader_ctrl
  import ofs_loader_pkg::*;
(
  input  logic   wrClk,
  input  logic   rdClk,
  input  logic   mrstN,
  input  logic   prstN,
  input  logic   ofsAccN,
  input  logic   senN,
  input  logic   wenN,
  input  logic   renN,
  output wrStb_t wrStb,
  output rdStb_t rdStb
);

  method_e method;
  logic    wrSel;
  logic    rdSel;
  logic    running;
  logic    parWr;
  logic    serShift;
  logic    rdGo;

  assign running  = mrstN && prstN;
  assign parWr    = running && !ofsAccN && !wenN && (method == METHOD_PAR);
  assign serShift = running && !ofsAccN && !senN && (method == METHOD_SER);
  assign rdGo     = running && !ofsAccN && !renN;

  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      method <= ofsAccN ? METHOD_SER : METHOD_PAR;
      wrSel  <= 1'b0;
    end else if (!prstN) begin
      wrSel  <= 1'b0;
    end else if (parWr) begin
      wrSel  <= ~wrSel;
    end
  end

  always_ff @(posedge rdClk) begin
    if (!running) begin
      rdSel <= 1'b0;
    end else if (rdGo) begin
      rdSel <= ~rdSel;
    end
  end

  always_comb begin
    wrStb.setDefault = !mrstN;
    wrStb.defSerial  = ofsAccN;
    wrStb.wrEmpty    = parWr && !wrSel;
    wrStb.wrFull     = parWr && wrSel;
    wrStb.shift      = serShift;
    rdStb.clear      = !running;
    rdStb.rdEmpty    = rdGo && !rdSel;
    rdStb.rdFull     = rdGo && rdSel;
  end

  // R3
  wrsel_toggle_chk: assert property (@(posedge wrClk) disable iff (!mrstN || !prstN)
    parWr |=> (wrSel != $past(wrSel)));

  // R6
  ld_idle_wrsel_chk: assert property (@(posedge wrClk) disable iff (!mrstN || !prstN)
    ofsAccN |=> $stable(wrSel));

  // R7
  method_hold_chk: assert property (@(posedge wrClk) disable iff (!mrstN)
    1'b1 |=> $stable(method));

  // R5
  rdsel_toggle_chk: assert property (@(posedge rdClk) disable iff (!mrstN || !prstN)
    rdGo |=> (rdSel != $past(rdSel)));

endmodule

// File: rtl/ofs_loader_dp.sv
module ofs_loader_dp
  import ofs_loader_pkg::*;
#(
  parameter int DW = 18,
  parameter int W  = 13
)(
  input  logic          wrClk,
  input  logic          rdClk,
  input  wrStb_t        wrStb,
  input  rdStb_t        rdStb,
  input  logic [DW-1:0] dataIn,
  input  logic          serIn,
  output logic [W-1:0]  emptyOfs,
  output logic [W-1:0]  fullOfs,
  output logic [DW-1:0] rdData
);

  localparam int CW = 2 * W;
  localparam logic [W-1:0] DEF_SER = (W >= 10) ? W'(1023) : {W{1'b1}};
  localparam logic [W-1:0] DEF_PAR = (W >= 7)  ? W'(127)  : {W{1'b1}};

  logic [CW-1:0] chain;
  logic [W-1:0]  wrWord;
  logic [W-1:0]  defWord;
  logic [DW-1:0] extEmpty;
  logic [DW-1:0] extFull;

  assign emptyOfs = chain[W-1:0];
  assign fullOfs  = chain[CW-1:W];
  assign defWord  = wrStb.defSerial ? DEF_SER : DEF_PAR;

  generate
    if (DW > W) begin : g_wide
      assign wrWord   = dataIn[W-1:0];
      assign extEmpty = {{(DW-W){1'b0}}, emptyOfs};
      assign extFull  = {{(DW-W){1'b0}}, fullOfs};
    end else if (DW == W) begin : g_equal
      assign wrWord   = dataIn;
      assign extEmpty = emptyOfs;
      assign extFull  = fullOfs;
    end else begin : g_narrow
      assign wrWord   = {{(W-DW){1'b0}}, dataIn};
      assign extEmpty = emptyOfs[DW-1:0];
      assign extFull  = fullOfs[DW-1:0];
    end
  endgenerate

  always_ff @(posedge wrClk) begin
    if (wrStb.setDefault) begin
      chain <= {defWord, defWord};
    end else if (wrStb.shift) begin
      chain <= {serIn, chain[CW-1:1]};
    end else if (wrStb.wrEmpty) begin
      chain[W-1:0] <= wrWord;
    end else if (wrStb.wrFull) begin
      chain[CW-1:W] <= wrWord;
    end
  end

  always_ff @(posedge rdClk) begin
    if (rdStb.clear) begin
      rdData <= '0;
    end else if (rdStb.rdEmpty) begin
      rdData <= extEmpty;
    end else if (rdStb.rdFull) begin
      rdData <= extFull;
    end
  end

  // R4
  shift_order_chk: assert property (@(posedge wrClk) disable iff (wrStb.setDefault)
    wrStb.shift |=> (emptyOfs[W-1] == $past(fullOfs[0])) && (fullOfs[W-1] == $past(serIn)));

  // R6
  ofs_hold_chk: assert property (@(posedge wrClk) disable iff (wrStb.setDefault)
    !(wrStb.shift || wrStb.wrEmpty || wrStb.wrFull) |=> $stable(chain));

  // R1
  def_serial_chk: assert property (@(posedge wrClk)
    (wrStb.setDefault && wrStb.defSerial) |=> (emptyOfs == DEF_SER) && (fullOfs == DEF_SER));

  // R2
  def_parallel_chk: assert property (@(posedge wrClk)
    (wrStb.setDefault && !wrStb.defSerial) |=> (emptyOfs == DEF_PAR) && (fullOfs == DEF_PAR));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_loader_pkg::*;
#(
  parameter int DEPTH = 8192,
  parameter int DW    = 18,
  localparam int W    = $clog2(DEPTH)
)(
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          ofsAccN,
  input  logic          senN,
  input  logic          wenN,
  input  logic          renN,
  input  logic          serIn,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] rdData,
  output logic [W-1:0]  emptyOfs,
  output logic [W-1:0]  fullOfs
);

  wrStb_t wrStb;
  rdStb_t rdStb;

  ofs_loader_ctrl ctrl_i (
    .wrClk   (wrClk),
    .rdClk   (rdClk),
    .mrstN   (mrstN),
    .prstN   (prstN),
    .ofsAccN (ofsAccN),
    .senN    (senN),
    .wenN    (wenN),
    .renN    (renN),
    .wrStb   (wrStb),
    .rdStb   (rdStb)
  );

  ofs_loader_dp #(.DW(DW), .W(W)) dp_i (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .wrStb    (wrStb),
    .rdStb    (rdStb),
    .dataIn   (dataIn),
    .serIn    (serIn),
    .emptyOfs (emptyOfs),
    .fullOfs  (fullOfs),
    .rdData   (rdData)
  );

endmodule

// File: tb/ofs_loader_tb_top.sv
`timescale 1ns/1ps
module ofs_loader_tb_top;

  localparam int DEPTH = 1024;
  localparam int DW    = 12;
  localparam int W     = 10;
  localparam int CW    = 2 * W;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic mrstN = 1'b0;
  logic prstN = 1'b1;
  logic ofsAccN = 1'b0;
  logic senN = 1'b1;
  logic wenN = 1'b1;
  logic renN = 1'b1;
  logic serIn = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] rdData;
  logic [W-1:0]  emptyOfs;
  logic [W-1:0]  fullOfs;

  int total = 0;
  int bad   = 0;

  always #2.5 wrClk = ~wrClk;
  always #3.5 rdClk = ~rdClk;

  ofs_loader #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .ofsAccN(ofsAccN), .senN(senN), .wenN(wenN), .renN(renN),
    .serIn(serIn), .dataIn(dataIn), .rdData(rdData),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic masterReset(input logic sel);
    ofsAccN = sel;
    mrstN = 1'b0;
    #30;
    @(negedge wrClk);
    mrstN = 1'b0;
    @(negedge wrClk);
    mrstN = 1'b1;
    ofsAccN = 1'b1;
    #20;
  endtask

  task automatic partialReset();
    @(negedge wrClk);
    prstN = 1'b0;
    #30;
    @(negedge wrClk);
    prstN = 1'b1;
    #20;
  endtask

  task automatic parWrite(input logic [DW-1:0] v);
    @(negedge wrClk);
    ofsAccN = 1'b0; wenN = 1'b0; dataIn = v;
    @(negedge wrClk);
    ofsAccN = 1'b1; wenN = 1'b1;
  endtask

  task automatic serBit(input logic b, input logic alsoWen);
    @(negedge wrClk);
    ofsAccN = 1'b0; senN = 1'b0; serIn = b; wenN = ~alsoWen; dataIn = '1;
    @(negedge wrClk);
    ofsAccN = 1'b1; senN = 1'b1; wenN = 1'b1;
  endtask

  task automatic readOne(output int v);
    @(negedge rdClk);
    ofsAccN = 1'b0; renN = 1'b0;
    @(negedge rdClk);
    ofsAccN = 1'b1; renN = 1'b1;
    v = int'(rdData);
  endtask

  task automatic readPair(input string tag, input int expE, input int expF);
    int v;
    readOne(v);
    check({tag, " read empty"}, v, expE);
    readOne(v);
    check({tag, " read full"}, v, expF);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mask = (1 << W) - 1;
    int ve, vf;
    logic [CW-1:0] chainExp;

    // R2: parallel method, defaults 127
    masterReset(1'b0);
    check("R2 empty default", int'(emptyOfs), 127);
    check("R2 full default", int'(fullOfs), 127);
    check("R2 rdData cleared", int'(rdData), 0);
    readPair("R5 after R2", 127, 127);

    // R3 sweep, upper bits above W-1 ignored; R5 readback zero-extended
    for (int i = 0; i < 16; i++) begin
      int a = (i * 397 + 5) & ((1 << DW) - 1);
      int b = (i * 1223 + 3071) & ((1 << DW) - 1);
      parWrite(DW'(a));
      parWrite(DW'(b));
      check("R3 empty write", int'(emptyOfs), a & mask);
      check("R3 full write", int'(fullOfs), b & mask);
      readPair("R5 sweep", a & mask, b & mask);
    end
    ve = int'(emptyOfs);
    vf = int'(fullOfs);

    // R6: enables with ofsAccN high touch nothing
    for (int i = 0; i < 6; i++) begin
      @(negedge wrClk);
      ofsAccN = 1'b1; wenN = 1'b0; senN = 1'b0; renN = 1'b0; dataIn = DW'(i * 77);
    end
    @(negedge wrClk);
    wenN = 1'b1; senN = 1'b1; renN = 1'b1;
    check("R6 empty held", int'(emptyOfs), ve);
    check("R6 full held", int'(fullOfs), vf);
    parWrite(DW'(11));
    check("R6 wr pointer at empty", int'(emptyOfs), 11);
    check("R6 full untouched", int'(fullOfs), vf);
    readPair("R6 rd pointer at empty", 11, vf);
    parWrite(DW'(vf));

    // R8: serial strobe ignored under parallel method
    for (int i = 0; i < 5; i++) serBit(1'b1, 1'b0);
    check("R8 par empty held", int'(emptyOfs), 11);
    check("R8 par full held", int'(fullOfs), vf);

    // R7: partial reset keeps values/method, resets pointers
    parWrite(DW'(200));                  // wr pointer now on full
    readOne(ve);                          // rd pointer now on full
    check("R7 pre read", ve, 200);
    partialReset();
    check("R7 empty kept", int'(emptyOfs), 200);
    check("R7 full kept", int'(fullOfs), vf);
    check("R7 rdData cleared", int'(rdData), 0);
    readPair("R7 rd pointer reset", 200, vf);
    parWrite(DW'(300));
    check("R7 wr pointer reset", int'(emptyOfs), 300);
    check("R7 method kept", int'(fullOfs), vf);

    // R1: serial method, defaults 1023
    masterReset(1'b1);
    check("R1 empty default", int'(emptyOfs), 1023);
    check("R1 full default", int'(fullOfs), 1023);
    check("R1 rdData cleared", int'(rdData), 0);

    // R4 sweep
    for (int i = 0; i < 6; i++) begin
      logic [CW-1:0] pat = CW'((i * 247719) ^ (i << 13) ^ 21'h0A5A5A);
      for (int k = 0; k < CW; k++) serBit(pat[k], 1'b0);
      check("R4 empty", int'(emptyOfs), int'(pat[W-1:0]));
      check("R4 full", int'(fullOfs), int'(pat[CW-1:W]));
      readPair("R5 serial method", int'(pat[W-1:0]), int'(pat[CW-1:W]));
    end
    chainExp = {fullOfs, emptyOfs};

    // R8: parallel strobe ignored under serial method
    for (int i = 0; i < 3; i++) parWrite(DW'(i + 5));
    check("R8 ser empty held", int'(emptyOfs), int'(chainExp[W-1:0]));
    check("R8 ser full held", int'(fullOfs), int'(chainExp[CW-1:W]));
    serBit(1'b1, 1'b1);
    chainExp = {1'b1, chainExp[CW-1:1]};
    check("R8 both strobes empty", int'(emptyOfs), int'(chainExp[W-1:0]));
    check("R8 both strobes full", int'(fullOfs), int'(chainExp[CW-1:W]));

    // R7 under serial method
    partialReset();
    check("R7 ser empty kept", int'(emptyOfs), int'(chainExp[W-1:0]));
    serBit(1'b0, 1'b0);
    chainExp = {1'b0, chainExp[CW-1:1]};
    check("R7 ser method kept", int'(fullOfs), int'(chainExp[CW-1:W]));
    check("R7 ser method kept empty", int'(emptyOfs), int'(chainExp[W-1:0]));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule